// File: doc/BRIEF.md
# Clock-Controlled LFSR Bit Combiner

This block produces one pseudo-random bit per enabled clock cycle by letting one maximal-length shift register decide how the output of another is used, rather than taking a single register's output bit directly. Two modes can be selected. In the shrinking mode a 67-bit control register gates the output bit of a 67-bit data register. In the alternating-step mode a 141-bit control register chooses which of two data registers, 131 and 137 bits wide, advances on that cycle, and the output is the XOR of the two data registers' output bits.

Before generation starts, software or a neighbouring block presents a seed for every register and pulses a load strobe. A zero seed is replaced by a fixed nonzero value, so no register can lock up. After the load, every cycle with enable high advances the registers of the selected mode and yields a registered output bit with a valid flag. The registers of the other mode keep their values, so a stream in one mode can pause while the other mode runs and then resume where it stopped.

Top module: `clkctl_lfsr_combiner`

## Requirements
- R1: While rst is high and afterwards until a load has completed, out_valid and out_bit are 0, even with enable high.
- R2: A cycle with load high copies every seed into its register and makes out_valid 0 on the following cycle. load takes priority over enable.
- R3: A seed equal to zero is stored as the value 1 (only bit 0 set).
- R4: Every register shifts toward its MSB. The new bit 0 is the XOR of the tap bits, and the register's output bit is its MSB. Taps use 1-based positions (position k is bit k-1): 67-bit {67,66,58,57}, 131-bit {131,130,84,83}, 137-bit {137,131}, 141-bit {141,140,110,109}.
- R5: mode = 0 selects the shrinking mode and mode = 1 selects the alternating-step mode. mode may change on any cycle.
- R6: In the shrinking mode both 67-bit registers step on each enabled cycle. out_bit is the data register's MSB when bit 0 of the control register is 1, and 0 otherwise, taken from the states before the step. The three alternating-step registers hold.
- R7: In the alternating-step mode the 141-bit register steps on each enabled cycle. If its MSB is 1, the 131-bit register steps and the 137-bit register holds. Otherwise the 137-bit register steps and the 131-bit register holds. out_bit is the XOR of the 131-bit and 137-bit MSBs before the step. The shrinking registers hold.
- R8: The outputs are registered. After a clock edge with enable=1, load=0 and a completed load, out_valid is 1 and out_bit carries the new bit. After any other edge, out_valid is 0 and out_bit is 0, and an edge with enable low leaves every register unchanged.
- R9: Outside reset, no register ever holds the all-zero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = shrinking, 1 = alternating-step |
| load | input | 1 | Seed load strobe |
| seed_sc | input | 67 | Seed, shrinking control register |
| seed_sd | input | 67 | Seed, shrinking data register |
| seed_ac | input | 141 | Seed, alternating-step control register |
| seed_a | input | 131 | Seed, 131-bit data register |
| seed_b | input | 137 | Seed, 137-bit data register |
| enable | input | 1 | Advance registers and produce a bit |
| out_bit | output | 1 | Generated bit |
| out_valid | output | 1 | out_bit holds a generated bit |

## Verification
A cycle-accurate model follows the stream across several hundred cycles in each mode from random seeds. This exposes any wrong tap, shift direction, gating bit or stepping choice, because each of these makes the sequences diverge quickly. Loading all-zero seeds, and then a single zero seed among nonzero ones, separates correct zero substitution from a register that locks at zero or loads the wrong constant. A phase with random enable and mode toggling checks that an idle cycle and the registers of the inactive mode hold their state, since any spurious step shifts every later bit. Enabling before the first load and reloading in the middle of a run show that valid stays low and that load overrides enable.

// File: rtl/clkctl_lfsr_pkg.sv
`timescale 1ns/1ps
package clkctl_lfsr_pkg;

  typedef enum logic {
    MODE_SHRINK = 1'b0,
    MODE_ALT    = 1'b1
  } gen_mode_e;

endpackage

// File: rtl/lfsr_cell.sv
`timescale 1ns/1ps
// Fibonacci shift register: shifts toward MSB, feedback into bit 0.
module lfsr_cell #(
  parameter int           W     = 8,
  parameter logic [W-1:0] TAPS  = W'(8'hB8),
  parameter int           SUBST = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         step,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] FILL = W'(SUBST);

  logic fb;
  assign fb = ^(q & TAPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= FILL;
    end else if (load) begin
      q <= (seed == '0) ? FILL : seed;
    end else if (step) begin
      q <= {q[W-2:0], fb};
    end
  end

endmodule

// File: rtl/clkctl_select.sv
`timescale 1ns/1ps
// Decides which registers advance and forms the next output bit.
module clkctl_select
  import clkctl_lfsr_pkg::*;
(
  input  gen_mode_e mode,
  input  logic      go,
  input  logic      sc_lsb,
  input  logic      sd_msb,
  input  logic      ac_msb,
  input  logic      a_msb,
  input  logic      b_msb,
  output logic      sh_step,
  output logic      ac_step,
  output logic      a_step,
  output logic      b_step,
  output logic      bit_nxt
);

  always_comb begin
    sh_step = 1'b0;
    ac_step = 1'b0;
    a_step  = 1'b0;
    b_step  = 1'b0;
    bit_nxt = 1'b0;
    if (go) begin
      if (mode == MODE_SHRINK) begin
        sh_step = 1'b1;
        bit_nxt = sc_lsb & sd_msb;
      end else begin
        ac_step = 1'b1;
        a_step  = ac_msb;
        b_step  = ~ac_msb;
        bit_nxt = a_msb ^ b_msb;
      end
    end
  end

endmodule

// File: rtl/clkctl_lfsr_combiner.sv
`timescale 1ns/1ps
module clkctl_lfsr_combiner
  import clkctl_lfsr_pkg::*;
#(
  parameter int W_SC = 67,
  parameter int W_SD = 67,
  parameter int W_AC = 141,
  parameter int W_A  = 131,
  parameter int W_B  = 137,
  parameter logic [W_SC-1:0] TAPS_SC = (W_SC'(1) << 66) | (W_SC'(1) << 65) |
                                       (W_SC'(1) << 57) | (W_SC'(1) << 56),
  parameter logic [W_SD-1:0] TAPS_SD = (W_SD'(1) << 66) | (W_SD'(1) << 65) |
                                       (W_SD'(1) << 57) | (W_SD'(1) << 56),
  parameter logic [W_AC-1:0] TAPS_AC = (W_AC'(1) << 140) | (W_AC'(1) << 139) |
                                       (W_AC'(1) << 109) | (W_AC'(1) << 108),
  parameter logic [W_A-1:0]  TAPS_A  = (W_A'(1) << 130) | (W_A'(1) << 129) |
                                       (W_A'(1) << 83)  | (W_A'(1) << 82),
  parameter logic [W_B-1:0]  TAPS_B  = (W_B'(1) << 136) | (W_B'(1) << 130),
  parameter int SEED_SUBST = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode,
  input  logic            load,
  input  logic [W_SC-1:0] seed_sc,
  input  logic [W_SD-1:0] seed_sd,
  input  logic [W_AC-1:0] seed_ac,
  input  logic [W_A-1:0]  seed_a,
  input  logic [W_B-1:0]  seed_b,
  input  logic            enable,
  output logic            out_bit,
  output logic            out_valid
);

  logic [W_SC-1:0] sc_q;
  logic [W_SD-1:0] sd_q;
  logic [W_AC-1:0] ac_q;
  logic [W_A-1:0]  a_q;
  logic [W_B-1:0]  b_q;

  logic loaded_q, go;
  logic sh_step, ac_step, a_step, b_step, bit_nxt;
  logic sc_lsb, sd_msb, ac_msb, a_msb, b_msb;
  gen_mode_e mode_e;

  assign mode_e = gen_mode_e'(mode);
  assign go     = enable & ~load & loaded_q;
  assign sc_lsb = sc_q[0];
  assign sd_msb = sd_q[W_SD-1];
  assign ac_msb = ac_q[W_AC-1];
  assign a_msb  = a_q[W_A-1];
  assign b_msb  = b_q[W_B-1];

  lfsr_cell #(.W(W_SC), .TAPS(TAPS_SC), .SUBST(SEED_SUBST)) u_sc (
    .clk(clk), .rst(rst), .load(load), .seed(seed_sc), .step(sh_step), .q(sc_q));
  lfsr_cell #(.W(W_SD), .TAPS(TAPS_SD), .SUBST(SEED_SUBST)) u_sd (
    .clk(clk), .rst(rst), .load(load), .seed(seed_sd), .step(sh_step), .q(sd_q));
  lfsr_cell #(.W(W_AC), .TAPS(TAPS_AC), .SUBST(SEED_SUBST)) u_ac (
    .clk(clk), .rst(rst), .load(load), .seed(seed_ac), .step(ac_step), .q(ac_q));
  lfsr_cell #(.W(W_A), .TAPS(TAPS_A), .SUBST(SEED_SUBST)) u_a (
    .clk(clk), .rst(rst), .load(load), .seed(seed_a), .step(a_step), .q(a_q));
  lfsr_cell #(.W(W_B), .TAPS(TAPS_B), .SUBST(SEED_SUBST)) u_b (
    .clk(clk), .rst(rst), .load(load), .seed(seed_b), .step(b_step), .q(b_q));

  clkctl_select u_sel (
    .mode(mode_e), .go(go),
    .sc_lsb(sc_lsb), .sd_msb(sd_msb), .ac_msb(ac_msb), .a_msb(a_msb), .b_msb(b_msb),
    .sh_step(sh_step), .ac_step(ac_step), .a_step(a_step), .b_step(b_step),
    .bit_nxt(bit_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded_q  <= 1'b0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      if (load) loaded_q <= 1'b1;
      out_valid <= go;
      out_bit   <= go & bit_nxt;
    end
  end

endmodule

// File: rtl/clkctl_lfsr_chk.sv
`timescale 1ns/1ps
module lfsr_cell_chk #(
  parameter int W     = 8,
  parameter int SUBST = 1
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic [W-1:0] seed,
  input logic         step,
  input logic [W-1:0] q
);

  p_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
    q != '0);

  p_zero_seed_r3: assert property (@(posedge clk) disable iff (rst)
    (load && seed == '0) |=> (q == W'(SUBST)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(q));

endmodule

module clkctl_lfsr_top_chk (
  input logic clk,
  input logic rst,
  input logic mode,
  input logic load,
  input logic enable,
  input logic loaded_q,
  input logic go,
  input logic sc_lsb,
  input logic ac_msb,
  input logic a_step,
  input logic b_step,
  input logic out_bit,
  input logic out_valid
);

  p_valid_gate_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> loaded_q);

  p_load_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> !out_valid);

  p_shrink_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (go && !mode && !sc_lsb) |=> !out_bit);

  p_alt_pick_r7: assert property (@(posedge clk) disable iff (rst)
    (go && mode) |-> ((a_step != b_step) && (a_step == ac_msb)));

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!out_valid && !out_bit));

endmodule

bind lfsr_cell lfsr_cell_chk #(.W(W), .SUBST(SUBST)) u_cell_chk (
  .clk(clk), .rst(rst), .load(load), .seed(seed), .step(step), .q(q));

bind clkctl_lfsr_combiner clkctl_lfsr_top_chk u_top_chk (
  .clk(clk), .rst(rst), .mode(mode), .load(load), .enable(enable),
  .loaded_q(loaded_q), .go(go), .sc_lsb(sc_lsb), .ac_msb(ac_msb),
  .a_step(a_step), .b_step(b_step), .out_bit(out_bit), .out_valid(out_valid));

// File: tb/clkctl_lfsr_combiner_tb.sv
`timescale 1ns/1ps
module clkctl_lfsr_combiner_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0;
  logic load = 1'b0;
  logic enable = 1'b0;
  logic [66:0]  seed_sc = '0;
  logic [66:0]  seed_sd = '0;
  logic [140:0] seed_ac = '0;
  logic [130:0] seed_a  = '0;
  logic [136:0] seed_b  = '0;
  logic out_bit, out_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state, each kept in a 141-bit variable
  logic [140:0] m_sc, m_sd, m_ac, m_a, m_b;
  bit m_loaded;

  always #5 clk = ~clk;

  clkctl_lfsr_combiner u_dut (
    .clk(clk), .rst(rst), .mode(mode), .load(load),
    .seed_sc(seed_sc), .seed_sd(seed_sd), .seed_ac(seed_ac),
    .seed_a(seed_a), .seed_b(seed_b), .enable(enable),
    .out_bit(out_bit), .out_valid(out_valid));

  // one step of a w-bit register; taps are 1-based positions, 0 = unused
  function automatic logic [140:0] adv(input logic [140:0] s, input int w,
                                       input int t0, input int t1,
                                       input int t2, input int t3);
    logic fb;
    logic [140:0] r;
    fb = 1'b0;
    if (t0 > 0) fb = fb ^ s[t0-1];
    if (t1 > 0) fb = fb ^ s[t1-1];
    if (t2 > 0) fb = fb ^ s[t2-1];
    if (t3 > 0) fb = fb ^ s[t3-1];
    r = s << 1;
    r[0] = fb;
    for (int i = w; i < 141; i++) r[i] = 1'b0;
    return r;
  endfunction

  function automatic logic [140:0] fix(input logic [140:0] s);
    return (s == '0) ? 141'd1 : s;
  endfunction

  function automatic logic [140:0] rnd();
    logic [159:0] v;
    v = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    return v[140:0];
  endfunction

  task automatic tick(input string tag);
    bit ev, eb, c;
    ev = 1'b0; eb = 1'b0;
    if (rst) begin
      m_loaded = 1'b0;
      m_sc = 141'd1; m_sd = 141'd1; m_ac = 141'd1; m_a = 141'd1; m_b = 141'd1;
    end else if (load) begin
      m_loaded = 1'b1;
      m_sc = fix(141'(seed_sc)); m_sd = fix(141'(seed_sd));
      m_ac = fix(141'(seed_ac)); m_a = fix(141'(seed_a)); m_b = fix(141'(seed_b));
    end else if (enable && m_loaded) begin
      ev = 1'b1;
      if (!mode) begin
        eb = m_sc[0] ? m_sd[66] : 1'b0;
        m_sc = adv(m_sc, 67, 67, 66, 58, 57);
        m_sd = adv(m_sd, 67, 67, 66, 58, 57);
      end else begin
        eb = m_a[130] ^ m_b[136];
        c = m_ac[140];
        m_ac = adv(m_ac, 141, 141, 140, 110, 109);
        if (c) m_a = adv(m_a, 131, 131, 130, 84, 83);
        else   m_b = adv(m_b, 137, 137, 131, 0, 0);
      end
    end
    @(posedge clk);
    #1;
    checks++;
    if (out_valid !== ev || out_bit !== eb) begin
      failures++;
      $display("FAIL %s t=%0t valid/bit actual=%b%b expected=%b%b",
               tag, $time, out_valid, out_bit, ev, eb);
    end
  endtask

  task automatic load_seeds(input string tag);
    load = 1'b1;
    tick(tag);
    load = 1'b0;
  endtask

  task automatic rand_seeds();
    logic [140:0] v;
    v = rnd(); seed_sc = v[66:0];
    v = rnd(); seed_sd = v[66:0];
    seed_ac = rnd();
    v = rnd(); seed_a = v[130:0];
    v = rnd(); seed_b = v[136:0];
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    // R1: reset state
    rst = 1'b1;
    tick("R1 reset");
    tick("R1 reset");
    rst = 1'b0;
    // R1: enable before any load gives nothing
    enable = 1'b1;
    for (int i = 0; i < 10; i++) tick("R1 no-load");

    // R2 R6 R4: shrinking mode from random seeds
    rand_seeds();
    mode = 1'b0;
    load_seeds("R2 load");
    for (int i = 0; i < 400; i++) tick("R6 R4 shrink");

    // R7 R4: alternating-step mode
    mode = 1'b1;
    for (int i = 0; i < 600; i++) tick("R7 R4 alt");

    // R2: load has priority over enable, mid-run reload
    rand_seeds();
    load_seeds("R2 reload");
    for (int i = 0; i < 100; i++) tick("R7 after reload");

    // R3: all-zero seeds
    seed_sc = '0; seed_sd = '0; seed_ac = '0; seed_a = '0; seed_b = '0;
    load_seeds("R3 zero load");
    mode = 1'b0;
    for (int i = 0; i < 200; i++) tick("R3 R6 zero-seed shrink");
    mode = 1'b1;
    for (int i = 0; i < 300; i++) tick("R3 R7 zero-seed alt");

    // R3: one zero seed among random ones
    rand_seeds();
    seed_b = '0;
    load_seeds("R3 partial zero");
    for (int i = 0; i < 300; i++) tick("R3 R7 partial zero");

    // R5 R8 R9: random enable and mode switching
    rand_seeds();
    load_seeds("R2 load");
    for (int i = 0; i < 1500; i++) begin
      enable = ($urandom_range(0, 3) != 0);
      mode = $urandom_range(0, 1);
      tick("R5 R8 R9 mixed");
    end

    // R8: idle cycles produce no valid, then the stream continues
    enable = 1'b0;
    for (int i = 0; i < 20; i++) tick("R8 idle");
    enable = 1'b1;
    for (int i = 0; i < 100; i++) tick("R8 resume");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule